// File: doc/BRIEF.md
# Staggered Per-Row Refresh Timeout Tracker

This block sits in a DRAM memory controller and keeps a small down-counting timeout for every (bank, row) pair. A row that ordinary traffic has just opened or closed has had its cells restored by that access, so its timeout is reloaded to the maximum value. The periodic mechanism asks for a refresh only when a row's timeout has run out. Rows that are busy with traffic therefore skip periodic refresh, and rows that are idle are still refreshed before their retention deadline.

The counters are split evenly into segments. Counter `{bank,row}` belongs to segment `flat % NUM_SEG` and sits at position `flat / NUM_SEG`, where `flat = {bank,row}`. A rotating position index advances once every `TICK_DIV` timebase ticks. At each such step, every segment examines the one counter at the current position. At most one refresh request per segment comes out per step, so demand is spread evenly over the interval and never gathers into a burst. Each request is a valid bit with a bank and row on its own lane, one lane per segment. This matches a downstream pending-refresh queue whose depth equals the number of segments.

The index visits each counter once per sweep of `2^POS_W` steps. The counter runs from its maximum value down to zero over `2^CNT_W` sweeps, which is one refresh interval. A row is therefore requested at least once in every `2^CNT_W` sweeps, counted from its last refresh or access.

Top module: `srt_refresh_tracker`

## Requirements
- R1: While `rst_n` is low, every `ref_valid_o` bit is 0. Reset loads the counter at position p of every segment with `p mod 2^CNT_W`, so the initial zero crossings are staggered.
- R2: A step happens on a clock edge only when `tick_i` is high and it is the `TICK_DIV`-th counted tick. Cycles with `tick_i` low are not counted. The position index advances by one per step and wraps from `2^POS_W-1` to 0.
- R3: At a step, segment s visits the counter with `flat = pos*2^SEG_W + s`. A request on lane s carries bank `flat[FLAT_W-1 -: BANK_W]` in `ref_bank_o[s*BANK_W +: BANK_W]` and row `flat[ROW_W-1:0]` in `ref_row_o[s*ROW_W +: ROW_W]`.
- R4: A visited counter that reads zero is reloaded to `2^CNT_W-1`. `ref_valid_o[s]` is then high for exactly the one cycle that follows the step.
- R5: A visited counter that reads nonzero is decremented by one, and no request is made for it.
- R6: An activate (`act_valid_i` with `act_bank_i`/`act_row_i`) reloads that row's counter to the maximum value.
- R7: A precharge (`pre_valid_i` with `pre_bank_i`/`pre_row_i`) reloads that row's counter to the maximum value.
- R8: If an activate or precharge targets the counter that is being visited in the same cycle, the counter is reloaded and no request is made, even if it read zero.
- R9: `ref_valid_o` is nonzero only in the cycle that directly follows a step.
- R10: For any pattern of accesses, a row's request comes at most `2^CNT_W * 2^POS_W` steps after its last refresh request, its last access, or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick |
| act_valid_i | input | 1 | Row activate event |
| act_bank_i | input | BANK_W | Bank of the activate |
| act_row_i | input | ROW_W | Row of the activate |
| pre_valid_i | input | 1 | Precharge (row close) event |
| pre_bank_i | input | BANK_W | Bank of the precharge |
| pre_row_i | input | ROW_W | Row of the precharge |
| ref_valid_o | output | 2^SEG_W | Refresh request, one bit per segment lane |
| ref_bank_o | output | 2^SEG_W*BANK_W | Bank of each lane's request |
| ref_row_o | output | 2^SEG_W*ROW_W | Row of each lane's request |

## Verification
The bench builds the tracker with 2 banks, 8 segments of 16 positions (128 rows), 2-bit counters and a tick divider of 2. With these values a full countdown lasts 64 steps, so each row goes through many reload and refresh cycles in a short run. Two-bit counters make zero-valued visits frequent, which lets the bench steer an access onto a zero counter exactly at its visit. The divider of 2, combined with sparse tick patterns, separates the tick count from the clock count. This makes the step timing and the refresh-deadline bound observable within a few thousand cycles.

// File: rtl/srt_pkg.sv
package srt_pkg;

  typedef enum logic [1:0] {
    LANE_IDLE = 2'd0,
    LANE_DEC  = 2'd1,
    LANE_FIRE = 2'd2,
    LANE_SKIP = 2'd3
  } lane_act_e;

  // staggered reset value for a counter at position pos
  function automatic int unsigned init_count(int unsigned pos, int unsigned cnt_w);
    return pos % (32'd1 << cnt_w);
  endfunction

  // counter left after a visit that no access disturbs
  function automatic int unsigned visit_next(int unsigned cur, int unsigned cnt_max);
    return (cur == 0) ? cnt_max : cur - 1;
  endfunction

endpackage

// File: rtl/srt_step_timer.sv
module srt_step_timer #(
  parameter int TICK_DIV = 4,
  parameter int POS_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic             step_o,
  output logic [POS_W-1:0] pos_o
);
  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [DIV_W-1:0] div_q;

  assign step_o = tick_i && (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pos_o <= '0;
    end else begin
      if (tick_i) begin
        div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
      end
      if (step_o) begin
        pos_o <= pos_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/srt_seg_lane.sv
module srt_seg_lane
  import srt_pkg::*;
#(
  parameter int POS_W = 4,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             act_hit_i,
  input  logic [POS_W-1:0] act_pos_i,
  input  logic             pre_hit_i,
  input  logic [POS_W-1:0] pre_pos_i,
  output lane_act_e        action_o,
  output logic             req_valid_o,
  output logic [POS_W-1:0] req_pos_o
);
  localparam int ROWS = 1 << POS_W;
  localparam int unsigned CNT_MAX = (32'd1 << CNT_W) - 1;

  logic [CNT_W-1:0] cnt_q [ROWS];
  logic             visit_touched;
  logic             visit_zero;

  assign visit_touched = (act_hit_i && (act_pos_i == pos_i)) ||
                         (pre_hit_i && (pre_pos_i == pos_i));
  assign visit_zero    = (cnt_q[pos_i] == '0);

  always_comb begin
    if (!step_i)            action_o = LANE_IDLE;
    else if (visit_touched) action_o = LANE_SKIP;
    else if (visit_zero)    action_o = LANE_FIRE;
    else                    action_o = LANE_DEC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < ROWS; p++) begin
        cnt_q[p] <= CNT_W'(init_count(p, CNT_W));
      end
    end else begin
      for (int p = 0; p < ROWS; p++) begin
        if ((act_hit_i && (act_pos_i == POS_W'(p))) ||
            (pre_hit_i && (pre_pos_i == POS_W'(p)))) begin
          cnt_q[p] <= CNT_W'(CNT_MAX);
        end else if (step_i && (pos_i == POS_W'(p))) begin
          cnt_q[p] <= CNT_W'(visit_next(cnt_q[p], CNT_MAX));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid_o <= 1'b0;
      req_pos_o   <= '0;
    end else begin
      req_valid_o <= (action_o == LANE_FIRE);
      if (step_i) req_pos_o <= pos_i;
    end
  end
endmodule

// File: rtl/srt_refresh_tracker.sv
module srt_refresh_tracker
  import srt_pkg::*;
#(
  parameter int BANK_W   = 1,
  parameter int SEG_W    = 3,
  parameter int POS_W    = 4,
  parameter int CNT_W    = 2,
  parameter int TICK_DIV = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   tick_i,
  input  logic                                   act_valid_i,
  input  logic [BANK_W-1:0]                      act_bank_i,
  input  logic [SEG_W+POS_W-BANK_W-1:0]          act_row_i,
  input  logic                                   pre_valid_i,
  input  logic [BANK_W-1:0]                      pre_bank_i,
  input  logic [SEG_W+POS_W-BANK_W-1:0]          pre_row_i,
  output logic [(1<<SEG_W)-1:0]                  ref_valid_o,
  output logic [(1<<SEG_W)*BANK_W-1:0]           ref_bank_o,
  output logic [(1<<SEG_W)*(SEG_W+POS_W-BANK_W)-1:0] ref_row_o
);
  localparam int NUM_SEG = 1 << SEG_W;
  localparam int FLAT_W  = SEG_W + POS_W;
  localparam int ROW_W   = FLAT_W - BANK_W;

  logic [FLAT_W-1:0]  act_flat, pre_flat;
  logic               step_w;
  logic [POS_W-1:0]   pos_w;
  logic [NUM_SEG-1:0] lane_skip;
  logic [NUM_SEG-1:0] lane_fire;

  assign act_flat = {act_bank_i, act_row_i};
  assign pre_flat = {pre_bank_i, pre_row_i};

  srt_step_timer #(.TICK_DIV(TICK_DIV), .POS_W(POS_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_i),
    .step_o (step_w),
    .pos_o  (pos_w)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_lane
    lane_act_e        action;
    logic             req_valid;
    logic [POS_W-1:0] req_pos;
    logic [FLAT_W-1:0] req_flat;

    srt_seg_lane #(.POS_W(POS_W), .CNT_W(CNT_W)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .step_i      (step_w),
      .pos_i       (pos_w),
      .act_hit_i   (act_valid_i && (act_flat[SEG_W-1:0] == SEG_W'(s))),
      .act_pos_i   (act_flat[FLAT_W-1:SEG_W]),
      .pre_hit_i   (pre_valid_i && (pre_flat[SEG_W-1:0] == SEG_W'(s))),
      .pre_pos_i   (pre_flat[FLAT_W-1:SEG_W]),
      .action_o    (action),
      .req_valid_o (req_valid),
      .req_pos_o   (req_pos)
    );

    assign lane_skip[s] = (action == LANE_SKIP);
    assign lane_fire[s] = (action == LANE_FIRE);
    assign req_flat     = {req_pos, SEG_W'(s)};

    assign ref_valid_o[s]                    = req_valid;
    assign ref_bank_o[s*BANK_W +: BANK_W]    = req_flat[FLAT_W-1 -: BANK_W];
    assign ref_row_o[s*ROW_W +: ROW_W]       = req_flat[ROW_W-1:0];
  end
endmodule

// File: rtl/srt_tracker_chk.sv
module srt_tracker_chk #(
  parameter int BANK_W   = 1,
  parameter int SEG_W    = 3,
  parameter int POS_W    = 4,
  parameter int CNT_W    = 2,
  parameter int TICK_DIV = 4
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    tick_i,
  input logic                                    step,
  input logic [POS_W-1:0]                        pos,
  input logic [(1<<SEG_W)-1:0]                   lane_skip,
  input logic [(1<<SEG_W)-1:0]                   lane_fire,
  input logic [(1<<SEG_W)-1:0]                   ref_valid,
  input logic [(1<<SEG_W)*BANK_W-1:0]            ref_bank,
  input logic [(1<<SEG_W)*(SEG_W+POS_W-BANK_W)-1:0] ref_row
);
  localparam int NUM_SEG = 1 << SEG_W;
  localparam int ROW_W   = SEG_W + POS_W - BANK_W;

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (ref_valid == '0);
    end
  end

  assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick_i);

  assert_pos_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (pos == POS_W'($past(pos) + 1'b1)));

  assert_quiet_off_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (ref_valid == '0));

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_lane_chk
    logic [SEG_W+POS_W-1:0] flat;
    assign flat = {ref_bank[s*BANK_W +: BANK_W], ref_row[s*ROW_W +: ROW_W]};

    assert_skip_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lane_skip[s] |=> !ref_valid[s]);

    assert_fire_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_fire[s] |=> ref_valid[s]);

    assert_req_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step ##1 ref_valid[s] |-> (flat[SEG_W-1:0] == SEG_W'(s)) &&
                                (flat[SEG_W+POS_W-1:SEG_W] == $past(pos)));
  end
endmodule

bind srt_refresh_tracker srt_tracker_chk #(
  .BANK_W(BANK_W), .SEG_W(SEG_W), .POS_W(POS_W), .CNT_W(CNT_W), .TICK_DIV(TICK_DIV)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .step      (step_w),
  .pos       (pos_w),
  .lane_skip (lane_skip),
  .lane_fire (lane_fire),
  .ref_valid (ref_valid_o),
  .ref_bank  (ref_bank_o),
  .ref_row   (ref_row_o)
);

// File: tb/tb_srt_refresh_tracker.sv
module tb_srt_refresh_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int BANK_W = 1, SEG_W = 3, POS_W = 4, CNT_W = 2, TICK_DIV = 2;
  localparam int NS = 1 << SEG_W, RPS = 1 << POS_W, TOTAL = NS * RPS;
  localparam int ROW_W = SEG_W + POS_W - BANK_W;
  localparam int RPB = TOTAL >> BANK_W;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int DEADLINE = (1 << CNT_W) * RPS;
  localparam int LIMIT = 100000;

  logic clk = 0, rst_n = 0, tick = 0;
  logic act_v = 0, pre_v = 0;
  logic [BANK_W-1:0] act_b = '0, pre_b = '0;
  logic [ROW_W-1:0]  act_r = '0, pre_r = '0;
  logic [NS-1:0]        ref_valid;
  logic [NS*BANK_W-1:0] ref_bank;
  logic [NS*ROW_W-1:0]  ref_row;

  always #(CLK_PERIOD/2) clk = ~clk;

  srt_refresh_tracker #(.BANK_W(BANK_W), .SEG_W(SEG_W), .POS_W(POS_W),
                        .CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .act_valid_i(act_v), .act_bank_i(act_b), .act_row_i(act_r),
    .pre_valid_i(pre_v), .pre_bank_i(pre_b), .pre_row_i(pre_r),
    .ref_valid_o(ref_valid), .ref_bank_o(ref_bank), .ref_row_o(ref_row));

  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference
  int mcnt [TOTAL];
  int last_evt [TOTAL];
  int mdiv, mpos, msteps;
  bit [NS-1:0] exp_valid;
  int exp_flat [NS];
  bit stepnow;

  always @(posedge clk) begin
    int af, pf;
    af = int'(act_b) * RPB + int'(act_r);
    pf = int'(pre_b) * RPB + int'(pre_r);
    if (!rst_n) begin
      for (int f = 0; f < TOTAL; f++) begin
        mcnt[f] = (f / NS) % (CMAX + 1);
        last_evt[f] = 0;
      end
      mdiv = 0; mpos = 0; msteps = 0; exp_valid = '0;
    end else begin
      stepnow = tick && (mdiv == TICK_DIV - 1);
      exp_valid = '0;
      if (tick) mdiv = (mdiv == TICK_DIV - 1) ? 0 : mdiv + 1;
      if (stepnow) begin
        msteps++;
        for (int s = 0; s < NS; s++) begin
          int f;
          f = mpos * NS + s;
          if ((act_v && af == f) || (pre_v && pf == f)) begin
          end else if (mcnt[f] == 0) begin
            mcnt[f] = CMAX; exp_valid[s] = 1; exp_flat[s] = f;
          end else begin
            mcnt[f] = mcnt[f] - 1;
          end
        end
        mpos = (mpos + 1) % RPS;
      end
      if (act_v) begin mcnt[af] = CMAX; last_evt[af] = msteps; end
      if (pre_v) begin mcnt[pf] = CMAX; last_evt[pf] = msteps; end
    end
  end

  task automatic fail_msg(string req, string what, int act, int expv);
    fails++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
  endtask

  // compare every cycle; tag names the requirement under test
  task automatic check_cycle();
    vectors++;
    if (ref_valid !== exp_valid)
      fail_msg(tag, "ref_valid", int'(ref_valid), int'(exp_valid));
    for (int s = 0; s < NS; s++) begin
      if (ref_valid[s] && exp_valid[s]) begin
        int df;
        df = int'(ref_bank[s*BANK_W +: BANK_W]) * RPB + int'(ref_row[s*ROW_W +: ROW_W]);
        vectors++;
        if (df != exp_flat[s]) fail_msg("R3", "request row", df, exp_flat[s]);
        // R10: deadline since last refresh or access
        vectors++;
        if (msteps - last_evt[df] > DEADLINE)
          fail_msg("R10", "steps since refresh", msteps - last_evt[df], DEADLINE);
        last_evt[df] = msteps;
      end
    end
  endtask

  task automatic run(int n, int tick_every, int act_pct, int pre_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_cycle();
      tick  = (tick_every > 0) && (($urandom % tick_every) == 0);
      act_v = ($urandom % 100) < act_pct;
      pre_v = ($urandom % 100) < pre_pct;
      act_b = BANK_W'($urandom); act_r = ROW_W'($urandom);
      pre_b = BANK_W'($urandom); pre_r = ROW_W'($urandom);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done) begin
      fail_msg("R2", "watchdog cycles", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (ref_valid !== '0) fail_msg("R1", "ref_valid in reset", int'(ref_valid), 0);
    rst_n = 1;
    tag = "R1 R4 R5 R9";  run(300, 1, 0, 0);
    tag = "R2";           run(400, 3, 0, 0);
    tag = "R2 R9";        run(200, 0, 0, 0);
    tag = "R6";           run(500, 1, 30, 0);
    tag = "R7";           run(500, 1, 0, 30);
    // R8: strike the visited row exactly at its visit
    tag = "R8";
    for (int i = 0; i < 300; i++) begin
      bit hit0;
      @(negedge clk);
      check_cycle();
      tick = 1; act_v = 0; pre_v = 0; hit0 = 0;
      if (mdiv == TICK_DIV - 1) begin
        int f;
        f = mpos * NS + (i % NS);
        hit0 = (mcnt[f] == 0);
        if (i % 2 == 0) begin act_v = 1; act_b = BANK_W'(f / RPB); act_r = ROW_W'(f % RPB); end
        else            begin pre_v = 1; pre_b = BANK_W'(f / RPB); pre_r = ROW_W'(f % RPB); end
        if (hit0) begin
          @(negedge clk);
          check_cycle();
          vectors++;
          if (ref_valid[i % NS] !== 1'b0)
            fail_msg("R8", "request on struck zero row", int'(ref_valid[i % NS]), 0);
          act_v = 0; pre_v = 0;
        end
      end
    end
    tag = "R6 R7 R10"; run(1500, 2, 20, 20);
    act_v = 0; pre_v = 0;
    tag = "R10"; run(300, 1, 0, 0);
    for (int f = 0; f < TOTAL; f++) begin
      vectors++;
      if (msteps - last_evt[f] >= DEADLINE)
        fail_msg("R10", "row overdue at end", msteps - last_evt[f], DEADLINE - 1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule